// File: doc/BRIEF.md
# Systolic GF(2^8) Inverter

This block returns the multiplicative inverse of a nonzero element of GF(2^8). The caller supplies the field modulus with each operand. The work is a bit-level extended Euclidean reduction laid out as a linear array of 2·DEG−1 = 15 rows, with a register after every row. A new operand can be presented on every clock, and each result leaves the last row a fixed number of cycles later, tagged by a valid flag that travels down the array with the data.

Each row has one control cell and one slice per bit. The control cell makes its decision from three things: the top bit of the working remainder, one sign bit, and a one-hot ring that tracks the degree gap between the two remainders. Because of this, no row contains an adder or a comparator, and no signal fans out across rows. The cofactors are kept as field elements. Each row applies a fixed scaling by x^-1 modulo the operand's own polynomial, and the chosen starting values make the total scaling over all rows cancel, so the value leaving the last row is the inverse itself.

Top module: `gfinv_array`

## Requirements
- R1: For any nonzero `elem_i` and an irreducible modulus x^8 + `mod_i`, the result on `inv_o` satisfies elem·inv ≡ 1. `mod_i` carries the coefficients of x^0..x^7, its bit 0 is 1, and the x^8 term is implied.
- R2: A result appears on `inv_o` with `out_vld_o` high exactly 15 rising edges after the edge that sampled its operand with `in_vld_i` high.
- R3: One operand is accepted on every clock edge with `in_vld_i` high, with no stall. Results come out in the order the operands went in, one per cycle.
- R4: The modulus is captured together with each operand. Consecutive operands may use different moduli, and each result is reduced by its own.
- R5: `out_vld_o` is high only in the cycles that correspond to accepted operands. Gaps in the input stream reappear as gaps of the same length at the output.
- R6: While `rst_ni` is low, `out_vld_o` is low. Operands presented while reset is held produce no result.
- R7: The element 1 gives 1. The element 0x02 (x) gives x^-1, which is `mod_i` shifted right by one with bit 7 set. The element 0xFF also gives its correct inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Operand valid |
| elem_i | input | 8 | Element to invert, bit k is the coefficient of x^k |
| mod_i | input | 8 | Low coefficients of the degree-8 modulus |
| out_vld_o | output | 1 | Result valid |
| inv_o | output | 8 | Inverse, bit k is the coefficient of x^k |

## Verification
The bench builds the block at the package default DEG = 8, which gives 15 rows and a one-hot ring of 9 bits. It feeds every nonzero element, back to back, under two different irreducible moduli, so every swap and shift path the rows can take is exercised, including the widest degree gaps the ring has to hold. A run that switches modulus on every operand shows that the polynomial is carried per operand. Streams with gaps, and operands offered while reset is held, expose any valid flag that is lost or invented.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;
  parameter int unsigned DEG = 8;
  localparam int unsigned ROWS = 2 * DEG - 1;

  typedef logic [DEG-1:0] elem_t;
  typedef logic [DEG:0]   poly_t;

  // u, v: remainders, top bit = x^DEG; t, s: cofactors as field elements
  typedef struct packed {
    poly_t u;
    poly_t v;
    elem_t t;
    elem_t s;
    elem_t g;
    logic  sgn;
    poly_t ring;
  } stage_t;

  // y * x^-1 mod (x^DEG + g), g[0] = 1
  function automatic elem_t div_x(elem_t y, elem_t g);
    elem_t z;
    z = y[0] ? (y ^ g) : y;
    return {y[0], z[DEG-1:1]};
  endfunction
endpackage

// File: rtl/gfinv_ctrl.sv
module gfinv_ctrl
  import gfinv_pkg::*;
(
  input  logic  v_top_i,
  input  logic  sgn_i,
  input  poly_t ring_i,
  output logic  c1_o,
  output logic  c2_o,
  output logic  sgn_o,
  output poly_t ring_o
);
  always_comb begin
    c1_o  = v_top_i;
    c2_o  = v_top_i & sgn_i;
    sgn_o = sgn_i ? ~v_top_i : ring_i[0];
    if (sgn_i && !v_top_i)       ring_o = {ring_i[DEG-1:0], 1'b0};
    else if (!sgn_i && !ring_i[0]) ring_o = {1'b0, ring_i[DEG:1]};
    else                         ring_o = ring_i;
  end
endmodule

// File: rtl/gfinv_cell.sv
module gfinv_cell (
  input  logic c1_i,
  input  logic c2_i,
  input  logic u_i,
  input  logic v_i,
  input  logic u_lo_i,
  input  logic v_lo_i,
  output logic u_o,
  output logic v_o
);
  assign u_o = c2_i ? v_i : u_i;
  assign v_o = v_lo_i ^ (c1_i & u_lo_i);
endmodule

// File: rtl/gfinv_row.sv
module gfinv_row
  import gfinv_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vld_i,
  input  stage_t d_i,
  output logic   vld_o,
  output stage_t q_o
);
  logic   c1, c2, sgn_n;
  poly_t  ring_n, u_n, v_n;
  elem_t  s_n, t_n;
  stage_t nxt;

  gfinv_ctrl u_ctrl (
    .v_top_i (d_i.v[DEG]),
    .sgn_i   (d_i.sgn),
    .ring_i  (d_i.ring),
    .c1_o    (c1),
    .c2_o    (c2),
    .sgn_o   (sgn_n),
    .ring_o  (ring_n)
  );

  for (genvar i = 0; i <= DEG; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      gfinv_cell u_cell (
        .c1_i(c1), .c2_i(c2), .u_i(d_i.u[i]), .v_i(d_i.v[i]),
        .u_lo_i(1'b0), .v_lo_i(1'b0), .u_o(u_n[i]), .v_o(v_n[i])
      );
    end else begin : g_mid
      gfinv_cell u_cell (
        .c1_i(c1), .c2_i(c2), .u_i(d_i.u[i]), .v_i(d_i.v[i]),
        .u_lo_i(d_i.u[i-1]), .v_lo_i(d_i.v[i-1]), .u_o(u_n[i]), .v_o(v_n[i])
      );
    end
  end

  always_comb begin
    s_n = c1 ? (d_i.s ^ d_i.t) : d_i.s;
    t_n = div_x(c2 ? d_i.s : d_i.t, d_i.g);
    nxt = '{u: u_n, v: v_n, t: t_n, s: s_n, g: d_i.g, sgn: sgn_n, ring: ring_n};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= vld_i;
  end

  always_ff @(posedge clk_i) q_o <= nxt;

  a_r2_vld_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r5_bubble_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r1_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && d_i.sgn && d_i.v[DEG]) |=> (q_o.u == $past(d_i.v) && !q_o.sgn));
  a_r1_u_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> q_o.u[DEG]);
  a_r1_ring_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $onehot0(q_o.ring));
endmodule

// File: rtl/gfinv_array.sv
module gfinv_array
  import gfinv_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_vld_i,
  input  logic [DEG-1:0] elem_i,
  input  logic [DEG-1:0] mod_i,
  output logic           out_vld_o,
  output logic [DEG-1:0] inv_o
);
  stage_t stg [ROWS+1];
  logic   vld [ROWS+1];

  // v = x*a, s = x^DEG mod g: total x^-1 scaling over ROWS rows cancels
  assign vld[0] = in_vld_i;
  assign stg[0] = '{u: {1'b1, mod_i}, v: {elem_i, 1'b0}, t: '0, s: mod_i,
                    g: mod_i, sgn: 1'b1, ring: poly_t'(1)};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    gfinv_row u_row (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld[r]),
      .d_i    (stg[r]),
      .vld_o  (vld[r+1]),
      .q_o    (stg[r+1])
    );
  end

  assign out_vld_o = vld[ROWS];
  assign inv_o     = stg[ROWS].t;

  a_r1_gcd_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (stg[ROWS].u == {1'b1, {DEG{1'b0}}}));
endmodule

// File: tb/gfinv_array_bench.sv
`timescale 1ns/1ps
module gfinv_array_bench;
  localparam int W   = 8;
  localparam int LAT = 2 * W - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] elem = '0;
  logic [W-1:0] modv = '0;
  logic         out_vld;
  logic [W-1:0] inv;

  gfinv_array u_gfinv_array (
    .clk_i(clk), .rst_ni(rst_ni), .in_vld_i(in_vld), .elem_i(elem),
    .mod_i(modv), .out_vld_o(out_vld), .inv_o(inv)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] g;
    logic [W-1:0] exp;
    int           stamp;
    string        tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [W-1:0] g);
    logic [W-1:0] p = '0;
    for (int i = W - 1; i >= 0; i--) begin
      p = p[W-1] ? ((p << 1) ^ g) : (p << 1);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [W-1:0] ref_inv(logic [W-1:0] a, logic [W-1:0] g);
    for (int b = 1; b < (1 << W); b++)
      if (ref_mul(a, W'(b), g) == W'(1)) return W'(b);
    return '0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] g, string tag);
    item_t it;
    @(negedge clk);
    in_vld = 1'b1;
    elem   = a;
    modv   = g;
    it.a = a; it.g = g; it.exp = ref_inv(a, g); it.stamp = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (out_vld) begin
        if (sb.size() == 0) begin
          check(1'b0, "R5", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc - it.stamp == LAT, "R2", cyc - it.stamp, LAT);
          check(inv == it.exp, it.tag, int'(inv), int'(it.exp));
        end
      end else if (sb.size() > 0 && sb[0].stamp + LAT == cyc) begin
        check(1'b0, "R3", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R6: reset holds valid low, operands offered in reset are dropped
    idle(2);
    check(out_vld == 1'b0, "R6", int'(out_vld), 0);
    repeat (3) begin
      @(negedge clk);
      in_vld = 1'b1; elem = 8'h53; modv = 8'h1B;
    end
    check(out_vld == 1'b0, "R6", int'(out_vld), 0);
    @(negedge clk);
    in_vld = 1'b0;
    rst_ni = 1'b1;
    idle(LAT + 5);
    check(out_vld == 1'b0, "R6", int'(out_vld), 0);

    // R7: boundary elements
    drive(8'h01, 8'h1D, "R7");
    drive(8'h02, 8'h1D, "R7");
    drive(8'hFF, 8'h1B, "R7");
    drive(8'h02, 8'h1B, "R7");
    idle(LAT + 2);
    check(ref_inv(8'h02, 8'h1B) == 8'h8D, "R7", int'(ref_inv(8'h02, 8'h1B)), 8'h8D);

    // R1: every element under x^8+x^4+x^3+x^2+1, back to back
    for (int a = 1; a < (1 << W); a++) drive(W'(a), 8'h1D, "R1");
    // R3: every element under x^8+x^4+x^3+x+1, no gap after previous sweep
    for (int a = 1; a < (1 << W); a++) drive(W'(a), 8'h1B, "R3");
    // R4: modulus alternates on every operand
    for (int a = 1; a < (1 << W); a++) drive(W'(a), a[0] ? 8'h1D : 8'h1B, "R4");
    idle(3);
    // R5: bubbles of varying length
    for (int k = 0; k < 40; k++) begin
      drive(W'(k * 7 + 3), 8'h1D, "R5");
      idle(k % 4);
    end
    idle(1);

    for (int k = 0; k < 400 && sb.size() > 0; k++) @(negedge clk);
    check(sb.size() == 0, "R2", sb.size(), 0);
    idle(LAT + 5);
    check(out_vld == 1'b0, "R5", int'(out_vld), 0);
    done = 1'b1;
    finish_run();
  end
endmodule